// File: doc/BRIEF.md
# Shaft speed protection trip unit

This block watches two turbine shafts, a high-pressure shaft and an optional low-pressure shaft. It raises trip flags when a shaft runs too fast or slows down too fast, when the low-pressure shaft speeds up too quickly, or when the rotor appears to be locked. Speed arrives as periodic samples together with a single strobe, `smp_valid`. Each sample is an unsigned count in which `UNITS_PER_PCT` counts equal one percent of rated speed, so by default 1000 means rated speed. The samples come at a fixed rate of `SMP_PER_SEC` per second.

A history state machine holds the two most recent samples for each shaft. It has three states:

- `HIST_EMPTY` is entered at reset.
- `HIST_PRIMED` is entered from `HIST_EMPTY` on the first strobe.
- `HIST_ARMED` is entered from `HIST_PRIMED` on the second strobe, and the block stays there on later strobes.

Only `rst_n` returns the machine to `HIST_EMPTY`.

Trip conditions are evaluated on every clock from the held samples and the live setpoint and enable inputs. They are registered into the flag outputs. The flags are positioned as follows:

| Bit | Trip |
|-----|------|
| 0 | high-pressure overspeed |
| 1 | high-pressure over-deceleration |
| 2 | low-pressure overspeed |
| 3 | low-pressure over-deceleration |
| 4 | low-pressure over-acceleration |
| 5 | locked rotor |

Bits 0 to 4 stay set until `master_reset` is applied. Bit 5 follows its condition. A 1 on any flag means trip, and a 0 means normal running.

Top module: `spd_trip_unit`

## Requirements
- R1: `trip_flags[0]` sets when the held high-pressure sample is above the active overspeed limit. A strobe captured at clock edge k shows on the flag after edge k+1.
- R2: While `test_sel` is 1, `test_limit` replaces both `hp_os_limit` and `lp_os_limit`. The change takes effect at the next clock edge, with no new sample needed.
- R3: `trip_flags[1]` sets when (previous − current) × `SMP_PER_SEC` on the high-pressure shaft exceeds 100 × `UNITS_PER_PCT`. That threshold is a fall of 100 % of rated speed per second.
- R4: `trip_flags[2]` and `trip_flags[3]` apply the rules of R1 and R3 to the low-pressure shaft against `lp_os_limit`. They can only set while `dual_en` is 1.
- R5: `trip_flags[4]` sets only when all of these hold:
  - `dual_en` is 1.
  - `accel_en` is 1.
  - (current − previous) × `SMP_PER_SEC` on the low-pressure shaft exceeds `accel_limit`.
  - The low-pressure sample is above `accel_min_speed`.
- R6: `trip_flags[5]` is 1 exactly while `lockrot_en` is 1 and one of these holds:
  - the high-pressure sample is below 1 % of rated speed;
  - `dual_en` is 1, the high-pressure sample is above 60 %, and the low-pressure sample is below 1 %.

  The flag is registered and not latched.
- R7: Each of `trip_flags[4:0]` stays 1 once set, until `master_reset` is applied.
- R8: A clock edge with `master_reset` at 1 loads each of bits 4:0 with its present condition. A bit whose condition still holds therefore stays 1.
- R9: After `rst_n`, all flags are 0. No flag can set before the first sample. The rate flags (bits 1, 3 and 4) cannot set before the second sample.
- R10: `trip_any` is the OR of all six flags.
- R11: The history state moves `HIST_EMPTY` → `HIST_PRIMED` → `HIST_ARMED` on successive strobes. `master_reset` does not move it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Strobe: both speed inputs hold a new sample |
| hp_speed | input | SPD_W | High-pressure shaft speed |
| lp_speed | input | SPD_W | Low-pressure shaft speed |
| hp_os_limit | input | SPD_W | Design overspeed limit, high-pressure shaft |
| lp_os_limit | input | SPD_W | Design overspeed limit, low-pressure shaft |
| test_limit | input | SPD_W | Substitute overspeed limit for testing |
| test_sel | input | 1 | Select `test_limit` for both shafts |
| accel_limit | input | ACC_W | Low-pressure rise-rate limit, in speed units per second |
| accel_min_speed | input | SPD_W | Low-pressure speed above which the acceleration check is active |
| dual_en | input | 1 | Enable the low-pressure checks |
| accel_en | input | 1 | Enable the over-acceleration check |
| lockrot_en | input | 1 | Enable the locked-rotor check |
| master_reset | input | 1 | Clear latched trips whose condition is gone |
| trip_flags | output | 6 | Trip bits, in the positions listed above |
| trip_any | output | 1 | Combined trip |

## Verification
The hardest situation to reach is a master reset that arrives while one latched condition has cleared and another has not. That case needs held samples whose level is already normal but whose last step was still a steep fall. The stimulus sets it up with an overspeed sample followed by a sharp drop, then applies `master_reset` before any further sample. A repeated sample afterwards removes the rate condition so that a second reset can clear it. Enable changes between samples are also driven, to show that a condition latent in the held samples latches as soon as its enable rises.

// File: rtl/spd_trip_pkg.sv
package spd_trip_pkg;

    typedef enum logic [1:0] {
        HIST_EMPTY,
        HIST_PRIMED,
        HIST_ARMED
    } hist_state_t;

    localparam int TRIP_N      = 6;
    localparam int T_HP_OS     = 0;
    localparam int T_HP_DECEL  = 1;
    localparam int T_LP_OS     = 2;
    localparam int T_LP_DECEL  = 3;
    localparam int T_LP_ACCEL  = 4;
    localparam int T_LOCKROT   = 5;

endpackage

// File: rtl/spd_history.sv
module spd_history
    import spd_trip_pkg::*;
#(
    parameter int SPD_W = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   smp_valid,
    input  logic [SPD_W-1:0]       hp_in,
    input  logic [SPD_W-1:0]       lp_in,
    output logic [1:0][SPD_W-1:0]  cur_spd,
    output logic [1:0][SPD_W-1:0]  prev_spd,
    output hist_state_t            state
);

    hist_state_t state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= HIST_EMPTY;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            HIST_EMPTY:  if (smp_valid) state_nxt = HIST_PRIMED;
            HIST_PRIMED: if (smp_valid) state_nxt = HIST_ARMED;
            HIST_ARMED:  state_nxt = HIST_ARMED;
            default:     state_nxt = HIST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_spd  <= '0;
            prev_spd <= '0;
        end else if (smp_valid) begin
            prev_spd <= cur_spd;
            cur_spd  <= {lp_in, hp_in};
        end
    end

endmodule

// File: rtl/spd_shaft_check.sv
module spd_shaft_check #(
    parameter int SPD_W         = 12,
    parameter int SMP_PER_SEC   = 100,
    parameter int UNITS_PER_PCT = 10
) (
    input  logic [SPD_W-1:0] cur,
    input  logic [SPD_W-1:0] prev,
    input  logic [SPD_W-1:0] os_limit,
    input  logic             level_ok,
    input  logic             rate_ok,
    output logic             over_speed,
    output logic             over_decel
);

    localparam logic [31:0] DECEL_LIM = 32'(100 * UNITS_PER_PCT);

    logic [31:0] drop_rate;

    always_comb begin
        drop_rate = '0;
        if (prev > cur) begin
            drop_rate = 32'(prev - cur) * 32'(SMP_PER_SEC);
        end
    end

    assign over_speed = level_ok && (cur > os_limit);
    assign over_decel = rate_ok && (drop_rate > DECEL_LIM);

endmodule

// File: rtl/spd_trip_latch.sv
module spd_trip_latch #(
    parameter int              N      = 6,
    parameter logic [N-1:0]    STICKY = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [N-1:0] cond,
    output logic [N-1:0] q
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        if (STICKY[i]) begin : g_sticky
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q[i] <= 1'b0;
                end else if (clr) begin
                    q[i] <= cond[i];
                end else begin
                    q[i] <= q[i] | cond[i];
                end
            end
        end else begin : g_follow
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q[i] <= 1'b0;
                end else begin
                    q[i] <= cond[i];
                end
            end
        end
    end

endmodule

// File: rtl/spd_trip_unit.sv
module spd_trip_unit
    import spd_trip_pkg::*;
#(
    parameter int SPD_W         = 12,
    parameter int ACC_W         = 20,
    parameter int SMP_PER_SEC   = 100,
    parameter int UNITS_PER_PCT = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [SPD_W-1:0]  hp_speed,
    input  logic [SPD_W-1:0]  lp_speed,
    input  logic [SPD_W-1:0]  hp_os_limit,
    input  logic [SPD_W-1:0]  lp_os_limit,
    input  logic [SPD_W-1:0]  test_limit,
    input  logic              test_sel,
    input  logic [ACC_W-1:0]  accel_limit,
    input  logic [SPD_W-1:0]  accel_min_speed,
    input  logic              dual_en,
    input  logic              accel_en,
    input  logic              lockrot_en,
    input  logic              master_reset,
    output logic [5:0]        trip_flags,
    output logic              trip_any
);

    localparam logic [SPD_W-1:0] ONE_PCT   = SPD_W'(UNITS_PER_PCT);
    localparam logic [SPD_W-1:0] SIXTY_PCT = SPD_W'(60 * UNITS_PER_PCT);
    localparam logic [TRIP_N-1:0] STICKY_MASK = TRIP_N'(~(1 << T_LOCKROT));

    hist_state_t               hist_state;
    logic [1:0][SPD_W-1:0]     cur_spd;
    logic [1:0][SPD_W-1:0]     prev_spd;
    logic [1:0][SPD_W-1:0]     os_lim;
    logic [1:0]                os_c;
    logic [1:0]                dc_c;
    logic                      level_ok;
    logic                      rate_ok;
    logic [31:0]               rise_rate;
    logic                      accel_c;
    logic                      lockrot_c;
    logic [TRIP_N-1:0]         cond;

    spd_history #(.SPD_W(SPD_W)) u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .hp_in     (hp_speed),
        .lp_in     (lp_speed),
        .cur_spd   (cur_spd),
        .prev_spd  (prev_spd),
        .state     (hist_state)
    );

    assign level_ok = (hist_state != HIST_EMPTY);
    assign rate_ok  = (hist_state == HIST_ARMED);

    assign os_lim[0] = test_sel ? test_limit : hp_os_limit;
    assign os_lim[1] = test_sel ? test_limit : lp_os_limit;

    for (genvar s = 0; s < 2; s++) begin : g_shaft
        spd_shaft_check #(
            .SPD_W         (SPD_W),
            .SMP_PER_SEC   (SMP_PER_SEC),
            .UNITS_PER_PCT (UNITS_PER_PCT)
        ) u_chk (
            .cur        (cur_spd[s]),
            .prev       (prev_spd[s]),
            .os_limit   (os_lim[s]),
            .level_ok   (level_ok),
            .rate_ok    (rate_ok),
            .over_speed (os_c[s]),
            .over_decel (dc_c[s])
        );
    end

    always_comb begin
        rise_rate = '0;
        if (cur_spd[1] > prev_spd[1]) begin
            rise_rate = 32'(cur_spd[1] - prev_spd[1]) * 32'(SMP_PER_SEC);
        end
    end

    assign accel_c = rate_ok && dual_en && accel_en &&
                     (rise_rate > 32'(accel_limit)) &&
                     (cur_spd[1] > accel_min_speed);

    assign lockrot_c = lockrot_en && level_ok &&
                       ((cur_spd[0] < ONE_PCT) ||
                        (dual_en && (cur_spd[0] > SIXTY_PCT) && (cur_spd[1] < ONE_PCT)));

    always_comb begin
        cond             = '0;
        cond[T_HP_OS]    = os_c[0];
        cond[T_HP_DECEL] = dc_c[0];
        cond[T_LP_OS]    = dual_en && os_c[1];
        cond[T_LP_DECEL] = dual_en && dc_c[1];
        cond[T_LP_ACCEL] = accel_c;
        cond[T_LOCKROT]  = lockrot_c;
    end

    spd_trip_latch #(.N(TRIP_N), .STICKY(STICKY_MASK)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (master_reset),
        .cond  (cond),
        .q     (trip_flags)
    );

    assign trip_any = |trip_flags;

endmodule

module spd_trip_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       smp_valid,
    input logic       dual_en,
    input logic       accel_en,
    input logic       lockrot_en,
    input logic       master_reset,
    input logic [5:0] trip_flags
);

    logic [1:0] n_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            n_seen <= '0;
        end else if (smp_valid && n_seen != 2'd2) begin
            n_seen <= n_seen + 2'd1;
        end
    end

    for (genvar i = 0; i < 5; i++) begin : g_hold
        // R7
        latched_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (trip_flags[i] && !master_reset) |=> trip_flags[i]);
    end

    // R9
    rate_after_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(trip_flags[1]) || $rose(trip_flags[3]) || $rose(trip_flags[4]))
        |-> ($past(n_seen) == 2'd2));

    // R4
    lp_needs_dual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(trip_flags[2]) || $rose(trip_flags[3])) |-> $past(dual_en));

    // R5
    accel_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trip_flags[4]) |-> ($past(accel_en) && $past(dual_en)));

    // R6
    lockrot_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lockrot_en |=> !trip_flags[5]);

endmodule

bind spd_trip_unit spd_trip_unit_chk u_trip_chk (.*);

// File: tb/sim_spd_trip_unit.sv
`timescale 1ns/1ps
module sim_spd_trip_unit;

    localparam int W   = 12;
    localparam int SPS = 100;
    localparam int UPP = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          smp_valid = 1'b0;
    logic [W-1:0]  hp_speed = '0;
    logic [W-1:0]  lp_speed = '0;
    logic [W-1:0]  hp_os_limit = 12'd1100;
    logic [W-1:0]  lp_os_limit = 12'd1050;
    logic [W-1:0]  test_limit = 12'd900;
    logic          test_sel = 1'b0;
    logic [19:0]   accel_limit = 20'd500;
    logic [W-1:0]  accel_min_speed = 12'd200;
    logic          dual_en = 1'b1;
    logic          accel_en = 1'b1;
    logic          lockrot_en = 1'b0;
    logic          master_reset = 1'b0;
    logic [5:0]    trip_flags;
    logic          trip_any;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    spd_trip_unit u0 (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
        .hp_speed(hp_speed), .lp_speed(lp_speed),
        .hp_os_limit(hp_os_limit), .lp_os_limit(lp_os_limit),
        .test_limit(test_limit), .test_sel(test_sel),
        .accel_limit(accel_limit), .accel_min_speed(accel_min_speed),
        .dual_en(dual_en), .accel_en(accel_en), .lockrot_en(lockrot_en),
        .master_reset(master_reset),
        .trip_flags(trip_flags), .trip_any(trip_any)
    );

    // Behavioural reference: last two samples kept in queues
    int hq[$];
    int lq[$];
    bit [5:0] exp_f = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            hq.delete();
            lq.delete();
            exp_f = '0;
        end else begin
            bit [5:0] c;
            int h, l, hp, lp, lim_h, lim_l;
            c = '0;
            if (hq.size() >= 1) begin
                h = hq[hq.size()-1];
                l = lq[lq.size()-1];
                lim_h = test_sel ? int'(test_limit) : int'(hp_os_limit);
                lim_l = test_sel ? int'(test_limit) : int'(lp_os_limit);
                c[0] = h > lim_h;
                c[2] = dual_en && (l > lim_l);
                c[5] = lockrot_en && ((h < UPP) ||
                       (dual_en && h > 60*UPP && l < UPP));
                if (hq.size() >= 2) begin
                    hp = hq[0];
                    lp = lq[0];
                    c[1] = (hp - h) * SPS > 100*UPP;
                    c[3] = dual_en && ((lp - l) * SPS > 100*UPP);
                    c[4] = dual_en && accel_en && ((l - lp) * SPS > int'(accel_limit))
                           && (l > int'(accel_min_speed));
                end
            end
            for (int i = 0; i < 5; i++)
                exp_f[i] = master_reset ? c[i] : (exp_f[i] | c[i]);
            exp_f[5] = c[5];
            if (smp_valid) begin
                hq.push_back(int'(hp_speed));
                lq.push_back(int'(lp_speed));
                if (hq.size() > 2) begin
                    void'(hq.pop_front());
                    void'(lq.pop_front());
                end
            end
        end
    end

    function automatic string bit_req(int i);
        case (i)
            0: return "R1";
            1: return "R3";
            2: return "R4";
            3: return "R4";
            4: return "R5";
            default: return "R6";
        endcase
    endfunction

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int i = 0; i < 6; i++) begin
                n_cmp++;
                if (trip_flags[i] !== exp_f[i]) begin
                    n_bad++;
                    $display("FAIL %s bit%0d got %b exp %b at %0t", bit_req(i), i,
                             trip_flags[i], exp_f[i], $time);
                end
            end
            n_cmp++;
            if (trip_any !== (|exp_f)) begin
                n_bad++;
                $display("FAIL R10 trip_any got %b exp %b", trip_any, |exp_f);
            end
        end
    end

    task automatic chk(string req, logic got, logic exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %b exp %b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic sample(int h, int l);
        @(negedge clk);
        hp_speed = W'(h);
        lp_speed = W'(l);
        smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic mreset();
        @(negedge clk);
        master_reset = 1'b1;
        @(negedge clk);
        master_reset = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R9", trip_any, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state all clear
        chk("R9", trip_flags == 6'd0, 1'b1);

        // R11: first sample primes history, no rate check possible yet
        sample(1000, 1000);
        chk("R11", trip_any, 1'b0);
        sample(1000, 1000);
        chk("R11", trip_any, 1'b0);

        // R1: overspeed above design limit 1100
        sample(1120, 1000);
        chk("R1", trip_flags[0], 1'b1);
        chk("R10", trip_any, 1'b1);

        // R3: drop of 120 units in one sample
        sample(1000, 1000);
        chk("R3", trip_flags[1], 1'b1);
        chk("R7", trip_flags[0], 1'b1);

        // R8: level gone, rate condition still present in held samples
        mreset();
        chk("R8", trip_flags[0], 1'b0);
        chk("R8", trip_flags[1], 1'b1);
        sample(1000, 1000);
        chk("R7", trip_flags[1], 1'b1);
        mreset();
        chk("R8", trip_flags[1], 1'b0);

        // R2: test limit 900 replaces design limit without new sample
        @(negedge clk); test_sel = 1'b1;
        repeat (2) @(negedge clk);
        chk("R2", trip_flags[0], 1'b1);
        @(negedge clk); test_sel = 1'b0;
        mreset();
        chk("R2", trip_flags[0], 1'b0);

        // R4: single-shaft mode ignores low-pressure overspeed
        @(negedge clk); dual_en = 1'b0;
        sample(1000, 1100);
        chk("R4", trip_flags[2], 1'b0);
        chk("R5", trip_flags[4], 1'b0);
        @(negedge clk); dual_en = 1'b1;
        repeat (2) @(negedge clk);
        chk("R4", trip_flags[2], 1'b1);
        chk("R5", trip_flags[4], 1'b1);
        sample(1000, 1000);
        chk("R4", trip_flags[3], 1'b1);
        sample(1000, 1000);
        mreset();
        chk("R8", trip_any, 1'b0);

        // R5: rise below the enable speed does not trip
        sample(1000, 100);
        sample(1000, 150);
        mreset();
        chk("R5", trip_flags[4], 1'b0);
        @(negedge clk); accel_en = 1'b0;
        sample(1000, 260);
        chk("R5", trip_flags[4], 1'b0);
        @(negedge clk); accel_en = 1'b1;
        repeat (2) @(negedge clk);
        chk("R5", trip_flags[4], 1'b1);
        sample(1000, 260);
        mreset();
        chk("R5", trip_flags[4], 1'b0);

        // R6: locked rotor, not latched
        @(negedge clk); lockrot_en = 1'b1;
        repeat (2) @(negedge clk);
        chk("R6", trip_flags[5], 1'b0);
        sample(700, 5);
        chk("R6", trip_flags[5], 1'b1);
        sample(700, 20);
        chk("R6", trip_flags[5], 1'b0);
        sample(5, 20);
        chk("R6", trip_flags[5], 1'b1);
        sample(700, 5);
        @(negedge clk); dual_en = 1'b0;
        repeat (2) @(negedge clk);
        chk("R6", trip_flags[5], 1'b0);
        @(negedge clk); dual_en = 1'b1; lockrot_en = 1'b0;
        repeat (2) @(negedge clk);
        chk("R6", trip_flags[5], 1'b0);

        // R9 / R11: after reset the first sample cannot give a rate trip
        do_reset();
        chk("R9", trip_any, 1'b0);
        sample(1000, 1000);
        chk("R9", trip_flags[1], 1'b0);
        sample(800, 1000);
        chk("R11", trip_flags[1], 1'b1);
        mreset();
        chk("R3", trip_flags[1], 1'b1);

        repeat (4) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(negedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: run did not end, got timeout exp completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule